// File: doc/BRIEF.md
# Typed Control and Status Register Bank

This block is a slave on a simple valid/ready configuration bus. It holds eight byte-wide registers at consecutive offsets, and each register has its own behaviour. There is a plain read/write control register, a read-only status input, and an event register with a mask register placed directly after it. There is also a register that software sets and hardware clears, a saturating event counter, a control register that pulses a strobe when it is written, and a status input that pulses a strobe when it is read.

A master raises `bus_valid` with the address, direction and write data, and holds them until it sees `bus_ready` for one cycle. Ready is produced only when every bit of `wait_clear` is high, so attached logic can stretch an access. Read data is taken from a one-hot select of the addressed register and is registered by default, so it is valid in the same cycle as ready. The event register feeds an active-low interrupt output through a registered flag.

Top module: `typed_csr_bank`

## Requirements
- R1: Offsets are 0 control, 1 status, 2 event, 3 event mask, 4 soft-set, 5 counter, 6 strobed control, 7 strobed status. The whole address is compared, and a read of any other address returns zero.
- R2: `bus_ready` is a one-cycle pulse. It rises on the cycle after an edge at which `bus_valid` is high, every `wait_clear` bit is high and ready is low. It is never high two cycles in a row.
- R3: While `bus_ready` is high after a read, `bus_rdata` holds the addressed register's value. The read data register loads on the edge at which ready rises.
- R4: The control register (offset 0) is writable, drives `ctl_out`, and resets to CTL_RST (0x5A by default).
- R5: The status register (offset 1) reads `stat_in`, and a write to it changes nothing.
- R6: The event register updates to (current OR `evt_set`) AND NOT (write data when it is written). Writing a 1 clears a bit, a write-one beats a same-cycle hardware set on the same bit, and other set bits still land.
- R7: `irq_n` is low on the cycle after an edge at which (event AND NOT mask) is nonzero, and high otherwise. The mask resets to all ones.
- R8: The soft-set register updates to (current OR write data when written) AND NOT `sset_clr`, so a clear beats a set. It drives `sset_out`.
- R9: A write to the counter (offset 5) loads it. Otherwise `cnt_inc` adds one each cycle, and the counter saturates at all ones.
- R10: `wcfg_stb` is high for one cycle after an edge at which ready is high on a write to offset 6. The register drives `wcfg_out`.
- R11: `rsts_stb` is high for one cycle after an edge at which ready is high on a read of offset 7, and the read returns `rsts_in`.
- R12: An asynchronous active-low `rst_n` at once forces the defaults: control 0x5A, mask 0xFF, and all other state zero. This gives `irq_n` high, ready low and both strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request, held until ready |
| bus_write | input | 1 | 1 write, 0 read |
| bus_addr | input | AW | Register offset |
| bus_wdata | input | DW | Write data |
| wait_clear | input | NWAIT | All high to allow completion |
| bus_ready | output | 1 | One-cycle completion pulse |
| bus_rdata | output | DW | Read data, valid with ready |
| ctl_out | output | DW | Control register value |
| stat_in | input | DW | Status value read at offset 1 |
| evt_set | input | DW | Hardware event set bits |
| irq_n | output | 1 | Active-low interrupt |
| sset_out | output | DW | Soft-set register value |
| sset_clr | input | DW | Hardware clear bits for soft-set |
| cnt_inc | input | 1 | Counter increment |
| wcfg_out | output | DW | Strobed control register value |
| wcfg_stb | output | 1 | Write strobe for offset 6 |
| rsts_in | input | DW | Status value read at offset 7 |
| rsts_stb | output | 1 | Read strobe for offset 7 |

## Verification
The checker watches several rules on every cycle. Ready never lasts two cycles and never follows an idle or blocked cycle. The interrupt follows the unmasked event bits one cycle later. Both strobes appear exactly one cycle after a matching ready and at no other time. A full counter stays full without a write, a hardware clear always removes soft-set bits, and at most one register is selected. Only the bench scenarios can show the stored values themselves: read-back per register, the write-one-versus-set collision result, the soft-set clear winning during a write, saturation after a run of increments, and the reset values.

// File: rtl/typed_csr_pkg.sv
`timescale 1ns/1ps
package typed_csr_pkg;
    localparam int unsigned NREG     = 8;
    localparam int unsigned OFS_CTL  = 0;
    localparam int unsigned OFS_STAT = 1;
    localparam int unsigned OFS_EVT  = 2;
    localparam int unsigned OFS_EMSK = 3;  // mask follows its event register
    localparam int unsigned OFS_SSET = 4;
    localparam int unsigned OFS_CNT  = 5;
    localparam int unsigned OFS_WCFG = 6;
    localparam int unsigned OFS_RSTS = 7;
endpackage

// File: rtl/csr_decode.sv
`timescale 1ns/1ps
module csr_decode #(
    parameter int unsigned AW   = 4,
    parameter int unsigned NREG = 8
) (
    input  logic            valid,
    input  logic            write,
    input  logic [AW-1:0]   addr,
    output logic [NREG-1:0] rd_sel,
    output logic [NREG-1:0] wr_sel
);
    for (genvar i = 0; i < NREG; i++) begin : g_sel
        localparam logic [AW-1:0] MY_OFS = AW'(i);
        always_comb begin
            rd_sel[i] = (addr == MY_OFS) && valid && !write;
            wr_sel[i] = (addr == MY_OFS) && valid && write;
        end
    end
endmodule

// File: rtl/csr_rdmux.sv
`timescale 1ns/1ps
module csr_rdmux #(
    parameter int unsigned DW   = 8,
    parameter int unsigned NREG = 8
) (
    input  logic [NREG-1:0]         sel,
    input  logic [NREG-1:0][DW-1:0] vals,
    output logic [DW-1:0]           dout
);
    // one-hot select, zero when nothing is selected
    always_comb begin
        dout = '0;
        for (int i = 0; i < NREG; i++) begin
            dout = dout | (vals[i] & {DW{sel[i]}});
        end
    end
endmodule

// File: rtl/csr_handshake.sv
`timescale 1ns/1ps
module csr_handshake #(
    parameter int unsigned DW     = 8,
    parameter int unsigned NWAIT  = 2,
    parameter bit          REG_RD = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  logic [NWAIT-1:0] wait_clear,
    input  logic [DW-1:0]    rd_mux,
    output logic             ready,
    output logic [DW-1:0]    rdata
);
    logic rdy_d, rdy_q;

    always_comb begin
        if (rdy_q)      rdy_d = 1'b0;
        else if (valid) rdy_d = &wait_clear;
        else            rdy_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdy_q <= 1'b0;
        else        rdy_q <= rdy_d;
    end

    assign ready = rdy_q;

    if (REG_RD) begin : g_regrd
        logic [DW-1:0] rd_d, rd_q;
        always_comb rd_d = rdy_d ? rd_mux : rd_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rd_q <= '0;
            else        rd_q <= rd_d;
        end
        assign rdata = rd_q;
    end else begin : g_combrd
        assign rdata = rd_mux;
    end
endmodule

// File: rtl/typed_csr_bank.sv
`timescale 1ns/1ps
module typed_csr_bank #(
    parameter int unsigned   AW       = 4,
    parameter int unsigned   DW       = 8,
    parameter int unsigned   NWAIT    = 2,
    parameter bit            REG_RD   = 1'b1,
    parameter logic [DW-1:0] CTL_RST  = 8'h5A,
    parameter logic [DW-1:0] MSK_RST  = '1,
    parameter logic [DW-1:0] SSET_RST = '0,
    parameter logic [DW-1:0] CNT_RST  = '0,
    parameter logic [DW-1:0] WCFG_RST = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_valid,
    input  logic             bus_write,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    input  logic [NWAIT-1:0] wait_clear,
    output logic             bus_ready,
    output logic [DW-1:0]    bus_rdata,
    output logic [DW-1:0]    ctl_out,
    input  logic [DW-1:0]    stat_in,
    input  logic [DW-1:0]    evt_set,
    output logic             irq_n,
    output logic [DW-1:0]    sset_out,
    input  logic [DW-1:0]    sset_clr,
    input  logic             cnt_inc,
    output logic [DW-1:0]    wcfg_out,
    output logic             wcfg_stb,
    input  logic [DW-1:0]    rsts_in,
    output logic             rsts_stb
);
    import typed_csr_pkg::*;

    typedef struct packed {
        logic [DW-1:0] ctl;
        logic [DW-1:0] evt;
        logic          irq_flag;
        logic [DW-1:0] emsk;
        logic [DW-1:0] sset;
        logic [DW-1:0] cnt;
        logic [DW-1:0] wcfg;
        logic          wstb;
        logic          rstb;
    } state_t;

    state_t st_d, st_q;

    logic [NREG-1:0]         rd_sel, wr_sel;
    logic [NREG-1:0][DW-1:0] rvals;
    logic [DW-1:0]           rd_mux;

    csr_decode #(.AW(AW), .NREG(NREG)) u_dec (
        .valid  (bus_valid),
        .write  (bus_write),
        .addr   (bus_addr),
        .rd_sel (rd_sel),
        .wr_sel (wr_sel)
    );

    always_comb begin
        rvals           = '0;
        rvals[OFS_CTL]  = st_q.ctl;
        rvals[OFS_STAT] = stat_in;
        rvals[OFS_EVT]  = st_q.evt;
        rvals[OFS_EMSK] = st_q.emsk;
        rvals[OFS_SSET] = st_q.sset;
        rvals[OFS_CNT]  = st_q.cnt;
        rvals[OFS_WCFG] = st_q.wcfg;
        rvals[OFS_RSTS] = rsts_in;
    end

    csr_rdmux #(.DW(DW), .NREG(NREG)) u_mux (
        .sel  (rd_sel),
        .vals (rvals),
        .dout (rd_mux)
    );

    csr_handshake #(.DW(DW), .NWAIT(NWAIT), .REG_RD(REG_RD)) u_hs (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid      (bus_valid),
        .wait_clear (wait_clear),
        .rd_mux     (rd_mux),
        .ready      (bus_ready),
        .rdata      (bus_rdata)
    );

    always_comb begin
        st_d = st_q;
        // plain control
        if (wr_sel[OFS_CTL]) st_d.ctl = bus_wdata;
        // event: hardware set, write-one-to-clear
        st_d.evt = (evt_set | st_q.evt) & ~({DW{wr_sel[OFS_EVT]}} & bus_wdata);
        st_d.irq_flag = |(st_q.evt & ~st_q.emsk);
        if (wr_sel[OFS_EMSK]) st_d.emsk = bus_wdata;
        // soft-set, hardware clear wins
        st_d.sset = (({DW{wr_sel[OFS_SSET]}} & bus_wdata) | st_q.sset) & ~sset_clr;
        // saturating counter
        if (wr_sel[OFS_CNT])                 st_d.cnt = bus_wdata;
        else if (cnt_inc && st_q.cnt != '1)  st_d.cnt = st_q.cnt + 1'b1;
        // strobed registers
        if (wr_sel[OFS_WCFG]) st_d.wcfg = bus_wdata;
        st_d.wstb = wr_sel[OFS_WCFG] & bus_ready;
        st_d.rstb = rd_sel[OFS_RSTS] & bus_ready;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctl      <= CTL_RST;
            st_q.evt      <= '0;
            st_q.irq_flag <= 1'b0;
            st_q.emsk     <= MSK_RST;
            st_q.sset     <= SSET_RST;
            st_q.cnt      <= CNT_RST;
            st_q.wcfg     <= WCFG_RST;
            st_q.wstb     <= 1'b0;
            st_q.rstb     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl_out  = st_q.ctl;
    assign irq_n    = ~st_q.irq_flag;
    assign sset_out = st_q.sset;
    assign wcfg_out = st_q.wcfg;
    assign wcfg_stb = st_q.wstb;
    assign rsts_stb = st_q.rstb;
endmodule

// File: rtl/typed_csr_checker.sv
`timescale 1ns/1ps
module typed_csr_checker #(
    parameter int unsigned AW    = 4,
    parameter int unsigned DW    = 8,
    parameter int unsigned NWAIT = 2,
    parameter int unsigned NREG  = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_valid,
    input logic             bus_write,
    input logic [AW-1:0]    bus_addr,
    input logic [NWAIT-1:0] wait_clear,
    input logic             bus_ready,
    input logic             irq_n,
    input logic [DW-1:0]    evt_q,
    input logic [DW-1:0]    msk_q,
    input logic [DW-1:0]    cnt_q,
    input logic [DW-1:0]    sset_out,
    input logic [DW-1:0]    sset_clr,
    input logic             wcfg_stb,
    input logic             rsts_stb,
    input logic [NREG-1:0]  rd_sel,
    input logic [NREG-1:0]  wr_sel
);
    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_sel | wr_sel)); // R1

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |=> !bus_ready); // R2

    AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |=> !bus_ready); // R2

    AST_READY_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        !(&wait_clear) |=> !bus_ready); // R2

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_q & ~msk_q) == '0) |=> irq_n); // R7

    AST_IRQ_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_q & ~msk_q) != '0) |=> !irq_n); // R7

    AST_SSET_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|sset_clr) |=> ((sset_out & $past(sset_clr)) == '0)); // R8

    AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '1 && !(bus_valid && bus_write && bus_addr == AW'(5))) |=> (cnt_q == '1)); // R9

    AST_WSTB_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ready && bus_valid && bus_write && bus_addr == AW'(6)) |=> wcfg_stb); // R10

    AST_WSTB_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        wcfg_stb |-> $past(bus_ready && bus_valid && bus_write && bus_addr == AW'(6))); // R10

    AST_RSTB_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ready && bus_valid && !bus_write && bus_addr == AW'(7)) |=> rsts_stb); // R11

    AST_RSTB_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        rsts_stb |-> $past(bus_ready && bus_valid && !bus_write && bus_addr == AW'(7))); // R11
endmodule

bind typed_csr_bank typed_csr_checker #(.AW(AW), .DW(DW), .NWAIT(NWAIT), .NREG(8)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .wait_clear (wait_clear),
    .bus_ready  (bus_ready),
    .irq_n      (irq_n),
    .evt_q      (st_q.evt),
    .msk_q      (st_q.emsk),
    .cnt_q      (st_q.cnt),
    .sset_out   (sset_out),
    .sset_clr   (sset_clr),
    .wcfg_stb   (wcfg_stb),
    .rsts_stb   (rsts_stb),
    .rd_sel     (rd_sel),
    .wr_sel     (wr_sel)
);

// File: tb/typed_csr_bank_bench.sv
`timescale 1ns/1ps
module typed_csr_bank_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_valid = 1'b0, bus_write = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [1:0] wait_clear = 2'b11;
    logic       bus_ready;
    logic [7:0] bus_rdata, ctl_out, sset_out, wcfg_out;
    logic [7:0] stat_in = 8'h3C, evt_set = '0, sset_clr = '0, rsts_in = 8'hA7;
    logic       irq_n, cnt_inc = 1'b0, wcfg_stb, rsts_stb;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    // model state
    logic [7:0] m_ctl = 8'h5A, m_evt = 8'h00, m_msk = 8'hFF, m_sset = 8'h00;
    logic [7:0] m_cnt = 8'h00, m_wcfg = 8'h00;

    always #2 clk = ~clk;

    typed_csr_bank u_typed_csr_bank (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .wait_clear(wait_clear),
        .bus_ready(bus_ready), .bus_rdata(bus_rdata), .ctl_out(ctl_out),
        .stat_in(stat_in), .evt_set(evt_set), .irq_n(irq_n), .sset_out(sset_out),
        .sset_clr(sset_clr), .cnt_inc(cnt_inc), .wcfg_out(wcfg_out),
        .wcfg_stb(wcfg_stb), .rsts_in(rsts_in), .rsts_stb(rsts_stb)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [3:0] a);
        case (a)
            4'd0: return m_ctl;
            4'd1: return stat_in;
            4'd2: return m_evt;
            4'd3: return m_msk;
            4'd4: return m_sset;
            4'd5: return m_cnt;
            4'd6: return m_wcfg;
            4'd7: return rsts_in;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic exp_irq_n();
        return !(|(m_evt & ~m_msk));
    endfunction

    // one access; side_evt / side_clr are held for the same cycles as valid
    task automatic xfer(input logic wr, input logic [3:0] a, input logic [7:0] d,
                        input logic [7:0] side_evt, input logic [7:0] side_clr,
                        output logic [7:0] rd);
        int n = 0;
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
        evt_set = side_evt; sset_clr = side_clr;
        do begin
            @(negedge clk);
            n++;
        end while (!bus_ready && n < 40);
        rd = bus_rdata;
        @(posedge clk);
        #1;
        bus_valid = 1'b0; evt_set = '0; sset_clr = '0;
        // model update
        if (wr && a == 4'd2) m_evt = (m_evt | side_evt) & ~d;
        else                 m_evt = m_evt | side_evt;
        if (wr && a == 4'd4) m_sset = (m_sset | d) & ~side_clr;
        else                 m_sset = m_sset & ~side_clr;
        if (wr) begin
            case (a)
                4'd0: m_ctl = d;
                4'd3: m_msk = d;
                4'd5: m_cnt = d;
                4'd6: m_wcfg = d;
                default: ;
            endcase
        end
        @(negedge clk);
        chk("R2 ready one cycle", {31'b0, bus_ready}, 32'd0);
        chk("R10 write strobe", {31'b0, wcfg_stb}, {31'b0, (wr && a == 4'd6)});
        chk("R11 read strobe", {31'b0, rsts_stb}, {31'b0, (!wr && a == 4'd7)});
        @(negedge clk);
        chk("R10 R11 strobe single", {30'b0, wcfg_stb, rsts_stb}, 32'd0);
    endtask

    task automatic settle_check();
        @(negedge clk);
        @(negedge clk);
        chk("R7 irq_n", {31'b0, irq_n}, {31'b0, exp_irq_n()});
        chk("R4 ctl_out", {24'b0, ctl_out}, {24'b0, m_ctl});
        chk("R8 sset_out", {24'b0, sset_out}, {24'b0, m_sset});
        chk("R10 wcfg_out", {24'b0, wcfg_out}, {24'b0, m_wcfg});
    endtask

    task automatic inc_cycles(input int n);
        @(negedge clk);
        cnt_inc = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            m_cnt = (m_cnt == 8'hFF) ? 8'hFF : m_cnt + 8'd1;
        end
        cnt_inc = 1'b0;
    endtask

    initial begin
        logic [7:0] rd;
        void'($urandom(32'h5EED_C0DE));
        #9 rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12 ctl reset", {24'b0, ctl_out}, 32'h5A);
        chk("R12 irq_n reset", {31'b0, irq_n}, 32'd1);
        chk("R12 ready reset", {31'b0, bus_ready}, 32'd0);
        chk("R12 sset/wcfg reset", {16'b0, sset_out, wcfg_out}, 32'd0);
        xfer(1'b0, 4'd3, 8'h00, 8'h00, 8'h00, rd);
        chk("R12 mask reset", {24'b0, rd}, 32'hFF);

        // R1 out of range, R5 status ignores writes
        xfer(1'b0, 4'd9, 8'h00, 8'h00, 8'h00, rd);
        chk("R1 unmapped read", {24'b0, rd}, 32'h00);
        xfer(1'b1, 4'd1, 8'hC3, 8'h00, 8'h00, rd);
        xfer(1'b0, 4'd1, 8'h00, 8'h00, 8'h00, rd);
        chk("R5 status read-only", {24'b0, rd}, {24'b0, stat_in});

        // R2 wait_clear blocks ready
        @(negedge clk);
        wait_clear = 2'b01;
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 4'd0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R2 ready held by wait", {31'b0, bus_ready}, 32'd0);
        end
        wait_clear = 2'b11;
        @(negedge clk);
        chk("R2 ready after wait", {31'b0, bus_ready}, 32'd1);
        chk("R3 rdata with ready", {24'b0, bus_rdata}, {24'b0, m_ctl});
        @(posedge clk);
        #1 bus_valid = 1'b0;
        @(negedge clk);

        // R7 masked event keeps irq high, then unmask and timing
        @(negedge clk); evt_set = 8'h10;
        @(negedge clk); evt_set = 8'h00; m_evt = 8'h10;
        @(negedge clk);
        chk("R7 masked irq", {31'b0, irq_n}, 32'd1);
        xfer(1'b1, 4'd3, 8'hEF, 8'h00, 8'h00, rd);
        settle_check();
        chk("R7 unmasked irq", {31'b0, irq_n}, 32'd0);
        xfer(1'b1, 4'd2, 8'h10, 8'h00, 8'h00, rd);
        settle_check();
        chk("R6 w1c clears", {31'b0, irq_n}, 32'd1);
        @(negedge clk); evt_set = 8'h10;
        @(negedge clk); evt_set = 8'h00; m_evt = 8'h10;
        chk("R7 irq lag one cycle", {31'b0, irq_n}, 32'd1);
        @(negedge clk);
        chk("R7 irq asserts", {31'b0, irq_n}, 32'd0);

        // R6 collision: bit2 set beforehand, hold sets 0x05 while writing 0x06
        xfer(1'b1, 4'd2, 8'hFF, 8'h00, 8'h00, rd);
        @(negedge clk); evt_set = 8'h04;
        @(negedge clk); evt_set = 8'h00; m_evt = 8'h04;
        xfer(1'b1, 4'd2, 8'h06, 8'h05, 8'h00, rd);
        xfer(1'b0, 4'd2, 8'h00, 8'h00, 8'h00, rd);
        chk("R6 collision", {24'b0, rd}, 32'h01);

        // R8 soft-set, clear beats set
        xfer(1'b1, 4'd4, 8'h0F, 8'h00, 8'h00, rd);
        xfer(1'b1, 4'd4, 8'hF0, 8'h00, 8'h11, rd);
        settle_check();
        chk("R8 clear priority", {24'b0, sset_out}, 32'hEE);

        // R9 saturation
        xfer(1'b1, 4'd5, 8'hFD, 8'h00, 8'h00, rd);
        inc_cycles(6);
        xfer(1'b0, 4'd5, 8'h00, 8'h00, 8'h00, rd);
        chk("R9 saturated", {24'b0, rd}, 32'hFF);

        // R10 / R11 strobes
        xfer(1'b1, 4'd6, 8'h77, 8'h00, 8'h00, rd);
        xfer(1'b0, 4'd7, 8'h00, 8'h00, 8'h00, rd);
        chk("R11 read value", {24'b0, rd}, 32'hA7);

        // random mix
        for (int k = 0; k < 300; k++) begin
            int op = $urandom_range(0, 5);
            logic [3:0] a = 4'($urandom_range(0, 9));
            logic [7:0] d = 8'($urandom);
            case (op)
                0, 1: xfer(1'b1, a, d, 8'h00, 8'h00, rd);
                2, 3: begin
                    xfer(1'b0, a, 8'h00, 8'h00, 8'h00, rd);
                    chk("R3 random read", {24'b0, rd}, {24'b0, exp_read(a)});
                end
                4: begin
                    @(negedge clk); evt_set = d;
                    @(negedge clk); evt_set = 8'h00; m_evt = m_evt | d;
                    @(negedge clk); sset_clr = 8'($urandom);
                    m_sset = m_sset & ~sset_clr;
                    @(negedge clk); sset_clr = 8'h00;
                end
                default: inc_cycles($urandom_range(1, 8));
            endcase
            if (k % 8 == 0) begin
                stat_in = 8'($urandom);
                rsts_in = 8'($urandom);
            end
            settle_check();
        end

        // R12 asynchronous reset mid-cycle
        xfer(1'b1, 4'd0, 8'h11, 8'h00, 8'h00, rd);
        @(negedge clk);
        #1 rst_n = 1'b0;
        #0.5;
        chk("R12 async ctl", {24'b0, ctl_out}, 32'h5A);
        chk("R12 async sset", {24'b0, sset_out}, 32'h00);
        chk("R12 async irq", {31'b0, irq_n}, 32'd1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule